// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block erases one block of an asynchronous NAND flash device and reports the result. A host presents a row address and a one-cycle start strobe. The block then drives the flash control pins and the 8-bit data bus through a fixed series of bus cycles. These are the erase setup command, the row-address bytes and the erase confirm command. It then waits for the ready/busy line to signal that the device has finished. Last, it writes the read-status command and reads back one status byte.

The outcome is returned as a one-cycle done pulse, a pass flag and a timeout flag. Every strobe width and every wait is a cycle-count parameter, so one netlist serves any clock rate. The data bus is split into an output, an output enable and an input, and the pads sit outside the block. The ready/busy input is synchronised inside the block.

Top module: `nand_erase_seq`

## Requirements
- R1: During and right after reset, chip enable, write strobe and read strobe are high (inactive), command latch and address latch are low, the bus output enable is low, and done, pass and timeout are low.
- R2: After start, exactly five write strobes are issued before busy waiting, each captured at the rising write strobe. The first carries command latch high and byte 60h. The next ROW_BYTES carry address latch high and the row address, least significant byte first. The last carries command latch high and byte D0h.
- R3: Every write-strobe low phase lasts exactly WE_LOW cycles, and the strobe stays high for at least WE_HIGH cycles between consecutive write strobes.
- R4: At least WB_CYC cycles pass between the rising strobe of D0h and the next write strobe.
- R5: The status command (command latch high, byte 70h) is written only after the synchronised ready/busy input reads high (ready).
- R6: The status byte is read with a single read strobe that stays low for exactly WE_LOW cycles. That strobe falls at least WHR_CYC cycles after the rising strobe of 70h. The bus output enable is low whenever the read strobe is low.
- R7: After a completed read, pass equals the inverse of status bit 0 (bit 0 = 0 means erase succeeded), and timeout is low.
- R8: If ready/busy stays low for BUSY_MAX cycles of busy waiting, the block ends with timeout high and pass low, writes no status command and issues no read strobe.
- R9: Chip enable stays low from the first command until the operation ends. It goes high in the cycle where done pulses. Done is high for exactly one cycle per operation.
- R10: A start strobe that arrives while an operation is in progress is ignored. The running sequence keeps its address, and no second operation follows.
- R11: Command latch and address latch are never high together, and the write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an erase |
| row_addr_i | input | 8*ROW_BYTES | Row address of the block, sampled on an accepted start |
| done_o | output | 1 | One-cycle pulse when the operation ends |
| pass_o | output | 1 | Erase succeeded; valid from done until the next start |
| timeout_o | output | 1 | Busy wait expired; valid from done until the next start |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb_n_i | input | 1 | Ready/busy from the device, low while busy |

## Verification
The bench sweeps row addresses with extreme and mixed byte values, status bytes with bit 0 both set and clear, and busy periods from none to tens of cycles. A reversed address byte order or a wrong strobe width would show up directly in the captured bus log. The model device drives the inverse of the status byte whenever the read strobe is high, so a block that samples the bus at the wrong moment reports the wrong pass flag. A block that ignored ready/busy would write 70h while the model is still busy. The bench also holds ready/busy low for good, and a block without a working timeout would never raise done or would go on to read status. A start pulsed during an operation must leave the address bytes unchanged and must not cause a second chip-enable assertion.

// File: rtl/nand_erase_pkg.sv
// Shared definitions for the NAND block erase sequencer.
// Assumes a single 8-bit device bus and one erase per request.
package nand_erase_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WB,
        ST_BUSY,
        ST_WHR,
        ST_READ
    } seq_state_e;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS      = 8'h70;
endpackage

// File: rtl/nand_strobe_gen.sv
// Generates one active-low strobe pulse per go request: LOW_CYC cycles low,
// then HIGH_CYC cycles high. Flags the last low cycle (data sample point)
// and the last high cycle (strobe complete). Assumes LOW_CYC, HIGH_CYC >= 1
// and that go_i is only raised while active_o is low.
module nand_strobe_gen #(
    parameter int LOW_CYC  = 3,
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic strobe_n_o,
    output logic sample_o,
    output logic end_o,
    output logic active_o
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic          active_q;
    logic          low_q;
    logic [CW-1:0] cnt_q;
    logic          low_last;
    logic          high_last;

    assign low_last  = low_q  && (cnt_q == CW'(LOW_CYC - 1));
    assign high_last = !low_q && (cnt_q == CW'(HIGH_CYC - 1));

    // Phase sequencer: idle -> low phase -> high phase -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            low_q    <= 1'b0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (go_i) begin
                active_q <= 1'b1;
                low_q    <= 1'b1;
                cnt_q    <= '0;
            end
        end else if (low_q) begin
            if (low_last) begin
                low_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (high_last) begin
            active_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pin and event decode.
    always_comb begin
        strobe_n_o = !(active_q && low_q);
        sample_o   = active_q && low_last;
        end_o      = active_q && high_last;
        active_o   = active_q;
    end

    // R3: the edge after the sample point always returns the strobe high.
    a_r3_rise_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> strobe_n_o);
endmodule

// File: rtl/nand_delay_ctr.sv
// Wait counter: restarts at zero on restart_i, counts up and holds at the
// limit. hit_o is high while the count equals the limit, so a state that
// restarts it on entry and leaves on hit_o lasts limit_i + 1 cycles.
module nand_delay_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic [CW-1:0] limit_i,
    output logic          hit_o
);
    logic [CW-1:0] cnt_q;

    // Count toward the limit, saturating there.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit compare.
    assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/nand_erase_seq.sv
// Erases one NAND block: writes setup command, row bytes (LSB first) and
// confirm command, waits out ready/busy, writes the status command and
// reads one status byte. Bit 0 of status clear means success. Assumes
// nand_rb_n_i is asynchronous (synchronised here) and that the pads
// combine nand_dq_o / nand_dq_oe_o / nand_dq_i into the device bus.
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int ROW_BYTES = 3,
    parameter int WE_LOW    = 3,
    parameter int WE_HIGH   = 2,
    parameter int WB_CYC    = 20,
    parameter int WHR_CYC   = 12,
    parameter int BUSY_MAX  = 1000000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [8*ROW_BYTES-1:0] row_addr_i,
    output logic                   done_o,
    output logic                   pass_o,
    output logic                   timeout_o,
    output logic                   nand_ce_n_o,
    output logic                   nand_cle_o,
    output logic                   nand_ale_o,
    output logic                   nand_we_n_o,
    output logic                   nand_re_n_o,
    output logic [7:0]             nand_dq_o,
    output logic                   nand_dq_oe_o,
    input  logic [7:0]             nand_dq_i,
    input  logic                   nand_rb_n_i
);
    localparam int ROW_W        = 8 * ROW_BYTES;
    localparam int CONFIRM_STEP = ROW_BYTES + 1;
    localparam int STATUS_STEP  = ROW_BYTES + 2;
    localparam int SW           = $clog2(STATUS_STEP + 1);
    localparam int T_A          = (WB_CYC > WHR_CYC) ? WB_CYC : WHR_CYC;
    localparam int T_MAX        = (BUSY_MAX > T_A) ? BUSY_MAX : T_A;
    localparam int CW           = $clog2(T_MAX + 1);

    seq_state_e       state_q, state_d;
    logic [SW-1:0]    step_q;
    logic [ROW_W-1:0] row_q;
    logic [1:0]       rb_sync_q;
    logic [7:0]       stat_q;
    logic             done_q, pass_q, tmo_q;
    logic             we_go, we_sample, we_end, we_active;
    logic             re_go, re_sample, re_end, re_active;
    logic             dly_hit, dly_restart;
    logic [CW-1:0]    dly_limit;
    logic             rb_ready, fin_ok, fin_to;
    logic [7:0]       dq_byte;

    assign rb_ready = rb_sync_q[1];
    assign we_go    = (state_q == ST_WRITE) && !we_active;
    assign re_go    = (state_q == ST_READ) && !re_active;
    assign fin_ok   = (state_q == ST_READ) && re_end;
    assign fin_to   = (state_q == ST_BUSY) && !rb_ready && dly_hit;

    nand_strobe_gen #(.LOW_CYC(WE_LOW), .HIGH_CYC(WE_HIGH)) we_gen_i (
        .clk(clk), .rst_n(rst_n), .go_i(we_go), .strobe_n_o(nand_we_n_o),
        .sample_o(we_sample), .end_o(we_end), .active_o(we_active));

    nand_strobe_gen #(.LOW_CYC(WE_LOW), .HIGH_CYC(WE_HIGH)) re_gen_i (
        .clk(clk), .rst_n(rst_n), .go_i(re_go), .strobe_n_o(nand_re_n_o),
        .sample_o(re_sample), .end_o(re_end), .active_o(re_active));

    nand_delay_ctr #(.CW(CW)) dly_i (
        .clk(clk), .rst_n(rst_n), .restart_i(dly_restart),
        .limit_i(dly_limit), .hit_o(dly_hit));

    // Next-state decision for the operation sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_WRITE;
            ST_WRITE: if (we_end) begin
                          if (step_q == SW'(CONFIRM_STEP))     state_d = ST_WB;
                          else if (step_q == SW'(STATUS_STEP)) state_d = ST_WHR;
                      end
            ST_WB:    if (dly_hit) state_d = ST_BUSY;
            ST_BUSY:  if (rb_ready) state_d = ST_WRITE;
                      else if (dly_hit) state_d = ST_IDLE;
            ST_WHR:   if (dly_hit) state_d = ST_READ;
            ST_READ:  if (re_end) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Wait counter control: restart on every state change, limit per state.
    always_comb begin
        dly_restart = (state_d != state_q);
        unique case (state_q)
            ST_WB:   dly_limit = CW'(WB_CYC - 1);
            ST_BUSY: dly_limit = CW'(BUSY_MAX - 1);
            default: dly_limit = CW'(WHR_CYC - 1);
        endcase
    end

    // Sequence state, captured request, status byte and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            row_q     <= '0;
            rb_sync_q <= '0;
            stat_q    <= '0;
            done_q    <= 1'b0;
            pass_q    <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            rb_sync_q <= {rb_sync_q[0], nand_rb_n_i};
            done_q    <= fin_ok || fin_to;
            if (state_q == ST_IDLE && start_i) begin
                row_q  <= row_addr_i;
                step_q <= '0;
                pass_q <= 1'b0;
                tmo_q  <= 1'b0;
            end
            if (we_end)    step_q <= step_q + 1'b1;
            if (re_sample) stat_q <= nand_dq_i;
            if (fin_ok)    pass_q <= !stat_q[0];
            if (fin_to)    tmo_q  <= 1'b1;
        end
    end

    // Byte placed on the bus for the current write step.
    always_comb begin
        dq_byte = 8'h00;
        if (step_q == '0)                        dq_byte = CMD_ERASE_SETUP;
        else if (step_q == SW'(CONFIRM_STEP))    dq_byte = CMD_ERASE_GO;
        else if (step_q == SW'(STATUS_STEP))     dq_byte = CMD_STATUS;
        for (int i = 0; i < ROW_BYTES; i++) begin
            if (step_q == SW'(i + 1)) dq_byte = row_q[8*i +: 8];
        end
    end

    // Device pin and result outputs.
    always_comb begin
        nand_ce_n_o  = (state_q == ST_IDLE);
        nand_dq_oe_o = (state_q == ST_WRITE);
        nand_dq_o    = dq_byte;
        nand_cle_o   = (state_q == ST_WRITE) &&
                       (step_q == '0 || step_q > SW'(ROW_BYTES));
        nand_ale_o   = (state_q == ST_WRITE) &&
                       (step_q != '0 && step_q <= SW'(ROW_BYTES));
        done_o       = done_q;
        pass_o       = pass_q;
        timeout_o    = tmo_q;
    end

    // R11: latch enables and strobes are mutually exclusive.
    a_r11_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle_o && nand_ale_o));
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n_o && !nand_re_n_o));
    // R6: the bus is released while the device drives it.
    a_r6_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n_o |-> !nand_dq_oe_o);
    // R2: a write strobe only starts with the bus driven and a latch enable set.
    a_r2_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n_o) |-> (nand_dq_oe_o && (nand_cle_o || nand_ale_o)));
    // R9: done is a single-cycle pulse that coincides with chip enable release.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_ce_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> nand_ce_n_o);
    // R10: the captured address does not move while an operation runs.
    a_r10_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_ce_n_o |=> $stable(row_q));
    // R8: a timeout never reports success.
    a_r8_timeout_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !pass_o);
endmodule

// File: tb/nand_erase_seq_tb_top.sv
`timescale 1ns/1ps
module nand_erase_seq_tb_top;
    localparam int P_RB   = 3;
    localparam int P_WP   = 3;
    localparam int P_WH   = 2;
    localparam int P_WB   = 4;
    localparam int P_WHR  = 5;
    localparam int P_BMAX = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] row_in = '0;
    logic        done, pass, tmo, ce_n, cle, ale, we_n, re_n, oe, rb_n;
    logic [7:0]  dq_o, dq_i, status_val;

    int checks = 0, fails = 0, cyc = 0;
    int busy_len = 0, busy_left = 0;
    logic [7:0] wr_byte [0:15];
    bit   wr_cle [0:15];
    bit   wr_ale [0:15];
    int wr_n, bad_low, bad_high, we_low, high_cnt, re_low, re_cnt, bad_re_low;
    int t_d0, t_70, gap_wb, gap_whr, done_cnt, ce_falls, t_done;
    bit early70, oe_in_re, ce_glitch, excl_bad, d_pass, d_tmo;
    logic we_prev = 1'b1, re_prev = 1'b1, ce_prev = 1'b1;

    always #2.5 clk = ~clk;

    assign rb_n = (busy_left > 0) ? 1'b0 : 1'b1;
    assign dq_i = re_n ? ~status_val : status_val;

    nand_erase_seq #(.ROW_BYTES(P_RB), .WE_LOW(P_WP), .WE_HIGH(P_WH),
        .WB_CYC(P_WB), .WHR_CYC(P_WHR), .BUSY_MAX(P_BMAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .row_addr_i(row_in),
        .done_o(done), .pass_o(pass), .timeout_o(tmo), .nand_ce_n_o(ce_n),
        .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_n_o(we_n),
        .nand_re_n_o(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(oe),
        .nand_dq_i(dq_i), .nand_rb_n_i(rb_n));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    // Bus monitor and device model, sampled on the falling clock edge.
    always @(negedge clk) begin
        cyc++;
        if (busy_left > 0) busy_left--;
        if (!we_n) begin
            if (we_prev) begin
                if (wr_n > 0 && high_cnt < P_WH) bad_high++;
                if (wr_n > 0 && wr_cle[wr_n-1] && wr_byte[wr_n-1] == 8'hD0)
                    gap_wb = cyc - t_d0;
                if (cle && dq_o == 8'h70 && (busy_left > 0 || rb_n == 1'b0))
                    early70 = 1'b1;
                we_low = 0;
            end
            we_low++;
        end else begin
            if (!we_prev) begin
                if (we_low != P_WP) bad_low++;
                if (wr_n < 16) begin
                    wr_byte[wr_n] = dq_o;
                    wr_cle[wr_n]  = cle;
                    wr_ale[wr_n]  = ale;
                end
                wr_n++;
                if (cle && dq_o == 8'hD0) begin t_d0 = cyc; busy_left = busy_len; end
                if (cle && dq_o == 8'h70) t_70 = cyc;
                high_cnt = 0;
            end
            high_cnt++;
        end
        if (!re_n) begin
            if (re_prev) begin gap_whr = cyc - t_70; re_low = 0; end
            re_low++;
            if (oe) oe_in_re = 1'b1;
        end else if (!re_prev) begin
            if (re_low != P_WP) bad_re_low++;
            re_cnt++;
        end
        if (done) begin done_cnt++; d_pass = pass; d_tmo = tmo; t_done = cyc; end
        if (ce_prev && !ce_n) ce_falls++;
        if (!ce_prev && ce_n && !done) ce_glitch = 1'b1;
        if ((cle && ale) || (!we_n && !re_n)) excl_bad = 1'b1;
        we_prev = we_n; re_prev = re_n; ce_prev = ce_n;
        if (cyc > 150000) begin
            chk(1'b0, "WD", "watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    task automatic clear_log();
        wr_n = 0; bad_low = 0; bad_high = 0; high_cnt = 0; re_cnt = 0;
        bad_re_low = 0; gap_wb = -1; gap_whr = -1; done_cnt = 0; ce_falls = 0;
        early70 = 0; oe_in_re = 0; ce_glitch = 0; excl_bad = 0; busy_left = 0;
        t_d0 = 0; t_70 = 0; t_done = 0;
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic run_op(input logic [23:0] row, input logic [7:0] st,
                          input int blen, input bit expect_to, input bit poke);
        int w;
        bit seq_ok;
        clear_log();
        status_val = st;
        busy_len = blen;
        @(negedge clk); #1; start = 1'b1; row_in = row;
        step(); start = 1'b0; row_in = ~row;
        if (poke) begin
            repeat (10) step();
            start = 1'b1; step(); start = 1'b0;
            repeat (40) step();
            start = 1'b1; step(); start = 1'b0;
        end
        w = 0;
        while (done_cnt == 0 && w < 5000) begin step(); w++; end
        chk(done_cnt != 0, "R9", "done not seen", w, 0);
        repeat (40) step();
        chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
        chk(ce_falls == 1 && !ce_glitch && ce_n, "R9", "chip enable span", ce_falls, 1);
        chk(!excl_bad, "R11", "exclusive controls", excl_bad, 0);
        chk(bad_low == 0, "R3", "write low width errors", bad_low, 0);
        chk(bad_high == 0, "R3", "write high too short", bad_high, 0);
        seq_ok = (wr_n >= 5);
        if (seq_ok) begin
            seq_ok = wr_cle[0] && !wr_ale[0] && wr_byte[0] == 8'h60 &&
                     wr_cle[4] && !wr_ale[4] && wr_byte[4] == 8'hD0;
            for (int i = 0; i < 3; i++)
                if (!wr_ale[i+1] || wr_cle[i+1] || wr_byte[i+1] != row[8*i +: 8])
                    seq_ok = 1'b0;
        end
        chk(seq_ok, poke ? "R10" : "R2", "erase write sequence", wr_n, 5);
        if (expect_to) begin
            chk(wr_n == 5 && re_cnt == 0, "R8", "no status after timeout", wr_n, 5);
            chk(d_tmo && !d_pass, "R8", "timeout flags", {d_tmo, d_pass}, 2'b10);
            chk(t_done - t_d0 >= P_BMAX, "R8", "timeout too early", t_done - t_d0, P_BMAX);
        end else begin
            chk(wr_n == 6 && wr_cle[5] && wr_byte[5] == 8'h70, "R5", "status command",
                wr_byte[5], 8'h70);
            chk(!early70, "R5", "status command while busy", early70, 0);
            chk(gap_wb >= P_WB + blen, "R4", "gap after confirm", gap_wb, P_WB);
            chk(re_cnt == 1 && bad_re_low == 0, "R6", "read strobe", re_cnt, 1);
            chk(gap_whr >= P_WHR && !oe_in_re, "R6", "read spacing / bus release",
                gap_whr, P_WHR);
            chk(d_pass == !st[0] && !d_tmo, "R7", "pass flag", {d_tmo, d_pass}, {1'b0, !st[0]});
        end
    endtask

    initial begin
        logic [23:0] rows [3];
        logic [7:0]  sts [4];
        int          bls [4];
        rows[0] = 24'h000000; rows[1] = 24'hFFFFFF; rows[2] = 24'h81C35A;
        sts[0] = 8'hE0; sts[1] = 8'hE1; sts[2] = 8'h00; sts[3] = 8'hFF;
        bls[0] = 0; bls[1] = 1; bls[2] = 7; bls[3] = 40;
        status_val = 8'h00;
        repeat (4) step();
        // R1: reset state.
        chk(ce_n && we_n && re_n && !cle && !ale && !oe && !done && !pass && !tmo,
            "R1", "outputs in reset", {ce_n, we_n, re_n, cle, ale, oe}, 6'b111000);
        rst_n = 1'b1;
        repeat (3) step();
        chk(ce_n && we_n && re_n && !cle && !ale && !oe && !done,
            "R1", "outputs after reset", {ce_n, we_n, re_n, cle, ale, oe}, 6'b111000);
        for (int a = 0; a < 3; a++)
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 4; b++)
                    run_op(rows[a], sts[s], bls[b], 1'b0, 1'b0);
        // R10: start pulses during a running operation.
        run_op(24'h3C9617, 8'hE0, 20, 1'b0, 1'b1);
        // R8: device never returns to ready.
        run_op(24'h123456, 8'hE0, 100000, 1'b1, 1'b0);
        busy_left = 0;
        // Recovery after a timeout.
        run_op(24'h0F1E2D, 8'hE1, 3, 1'b0, 1'b0);
        finish_run();
    end
endmodule